// File: doc/BRIEF.md
# Branch Prediction Front End

This block sits in the fetch stage and produces a one-cycle, combinational guess for every fetched instruction. It is built from three parts. A table of 8192 two-bit saturating counters gives the direction and is indexed by a global history register. A fully associative cache of 16 recently taken branch targets supplies target addresses. A 16-deep stack of return addresses serves subroutine returns. The fetch unit presents an address and a branch kind. The block answers with a taken flag, a predicted next address, a hit flag, and the history value that the fetch unit must carry with the branch as its checkpoint.

When a branch resolves in execution, the block receives its address, kind, outcome, actual target and checkpoint. Conditional outcomes train the counters. Taken conditional branches and taken calls write the target cache. If the resolution also carries a mispredict flush, the global history is rebuilt from the checkpoint. The return stack moves only on fetch and has no recovery.

Branch kind encoding on both ports: 2'b00 not a branch, 2'b01 conditional, 2'b10 call, 2'b11 return. Instructions are 4 bytes wide, so the fall-through address is the fetch address plus 4.

Top module: `bp_frontend`

## Requirements
- R1: After reset the history reads zero, every counter holds weakly not-taken (2'b01), the target cache is empty, and the return stack is empty.
- R2: For a conditional fetch, the counter index is the 13-bit history XOR fetch_pc[14:2]. The prediction is taken only when the counter's upper bit is set and the target cache hits. The target is then the cached target; otherwise it is fetch_pc+4, and pred_hit equals the cache hit.
- R3: A resolved conditional branch moves the counter at history-XOR-address index (using upd_ghr and upd_pc) one step toward its outcome. The encoding runs 2'b00 strongly not-taken to 2'b11 strongly taken, and the counter saturates at both ends.
- R4: A valid conditional fetch shifts its own predicted direction into bit 0 of the history, with older bits moving up one place.
- R5: A flush (upd_valid with upd_mispredict) loads the history from upd_ghr. For a conditional branch the actual outcome is also appended at bit 0, giving {upd_ghr[11:0], upd_taken}. A flush takes priority over a shift in the same cycle.
- R6: The target cache holds 16 entries tagged by the full word address. Only taken conditional or call resolutions write it: an existing entry is updated, otherwise one is allocated. Not-taken resolutions and returns leave it untouched.
- R7: Allocation picks an empty entry first, the highest-numbered one first. Once the cache is full it picks the least recently written entry, and a write to an existing entry counts as a use.
- R8: A call is predicted taken exactly when the target cache hits, and a valid call fetch pushes fetch_pc+4 onto the return stack.
- R9: A return with a non-empty stack predicts taken with hit set and the stack top as target, regardless of the target cache. A valid return fetch pops that entry.
- R10: The stack holds 16 addresses. A push onto a full stack overwrites the oldest address, so the 16 most recent pushes survive.
- R11: A return on an empty stack gives hit 0, taken 0, target fetch_pc+4, and leaves the stack empty.
- R12: A non-branch fetch gives hit 0, taken 0 and target fetch_pc+4. Without a flush, a fetch that is not a valid conditional leaves the history unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid | input | 1 | A fetch is presented and may change history and stack |
| fetch_pc | input | 32 | Fetch address |
| fetch_kind | input | 2 | Branch kind of the fetched instruction |
| pred_taken | output | 1 | Predicted taken |
| pred_hit | output | 1 | A target source (cache or stack) supplied a target |
| pred_target | output | 32 | Predicted next address |
| pred_ghr | output | 13 | Current global history, the checkpoint for this fetch |
| upd_valid | input | 1 | A branch resolution is presented |
| upd_pc | input | 32 | Resolved branch address |
| upd_kind | input | 2 | Resolved branch kind |
| upd_taken | input | 1 | Actual outcome |
| upd_target | input | 32 | Actual target |
| upd_ghr | input | 13 | History checkpoint carried with the branch |
| upd_mispredict | input | 1 | Flush: rebuild history from the checkpoint |

## Verification
Some rules are checked on every cycle. These cover the history shift, the restore and hold on flush, the stack depth bound and its push and pop counting, the empty-stack and non-branch outputs, the rule that a conditional is never predicted taken without a cached target, and the presence of exactly one replacement candidate. Other behaviour can only be shown by the bench's scenarios. This includes counter saturation after repeated training, which entry gets evicted after a long history of fills and refreshes, and which return addresses survive a stack overflow. The bench covers these by comparing every prediction with its own model of the counters, target cache and stack.

// File: rtl/bp_pkg.sv
package bp_pkg;

  typedef enum logic [1:0] {
    BK_NONE = 2'b00,
    BK_COND = 2'b01,
    BK_CALL = 2'b10,
    BK_RET  = 2'b11
  } br_kind_e;

  // counter encoding: 00 strong not-taken .. 11 strong taken
  localparam logic [1:0] CTR_WEAK_NT = 2'b01;

  function automatic logic [1:0] sat2_step(input logic [1:0] c, input logic up);
    if (up) return (c == 2'b11) ? c : c + 2'b01;
    return (c == 2'b00) ? c : c - 2'b01;
  endfunction

  function automatic logic ctr_says_taken(input logic [1:0] c);
    return c[1];
  endfunction

endpackage

// File: rtl/bp_dir_table.sv
module bp_dir_table import bp_pkg::*; #(
  parameter int IDX_W  = 13,
  parameter int LANE_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_bits,
  input  logic [IDX_W-1:0] rd_hist,
  output logic [1:0]       rd_ctr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_bits,
  input  logic [IDX_W-1:0] wr_hist,
  input  logic             wr_taken
);
  // counters are packed LANES to a row so the storage is a few wide words
  localparam int ROW_W = IDX_W - LANE_W;
  localparam int ROWS  = 1 << ROW_W;
  localparam int LANES = 1 << LANE_W;
  localparam int WORD  = 2 * LANES;

  logic [WORD-1:0] rows_q [ROWS];

  function automatic logic [IDX_W-1:0] hist_index(input logic [IDX_W-1:0] addr_bits,
                                                  input logic [IDX_W-1:0] hist);
    return addr_bits ^ hist;
  endfunction

  logic [IDX_W-1:0] rd_idx, wr_idx;
  logic [WORD-1:0]  rd_row, wr_row;
  logic [1:0]       wr_old;

  assign rd_idx = hist_index(rd_bits, rd_hist);
  assign wr_idx = hist_index(wr_bits, wr_hist);
  assign rd_row = rows_q[rd_idx[IDX_W-1:LANE_W]];
  assign wr_row = rows_q[wr_idx[IDX_W-1:LANE_W]];
  assign rd_ctr = rd_row[{rd_idx[LANE_W-1:0], 1'b0} +: 2];
  assign wr_old = wr_row[{wr_idx[LANE_W-1:0], 1'b0} +: 2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++) rows_q[r] <= {LANES{CTR_WEAK_NT}};
    end else if (wr_en) begin
      rows_q[wr_idx[IDX_W-1:LANE_W]][{wr_idx[LANE_W-1:0], 1'b0} +: 2] <= sat2_step(wr_old, wr_taken);
    end
  end

endmodule

// File: rtl/bp_target_cache.sv
module bp_target_cache #(
  parameter int PC_W    = 32,
  parameter int TAG_W   = 30,
  parameter int ENTRIES = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [TAG_W-1:0]   lk_tag,
  output logic               lk_hit,
  output logic [PC_W-1:0]    lk_target,
  input  logic               wr_en,
  input  logic [TAG_W-1:0]   wr_tag,
  input  logic [PC_W-1:0]    wr_target,
  output logic [ENTRIES-1:0] victim_vec
);
  localparam int AGE_W = $clog2(ENTRIES);
  localparam logic [AGE_W-1:0] OLDEST = AGE_W'(ENTRIES - 1);

  logic [ENTRIES-1:0] valid_q;
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [PC_W-1:0]    tgt_q [ENTRIES];
  logic [AGE_W-1:0]   age_q [ENTRIES];

  logic [ENTRIES-1:0] lk_match, wr_match, sel_vec;
  logic [AGE_W-1:0]   sel_age;

  // ages form a permutation; empty entries always hold the oldest ages
  generate
    for (genvar g = 0; g < ENTRIES; g++) begin : g_way
      assign lk_match[g]   = valid_q[g] && (tag_q[g] == lk_tag);
      assign wr_match[g]   = valid_q[g] && (tag_q[g] == wr_tag);
      assign victim_vec[g] = (age_q[g] == OLDEST);
    end
  endgenerate

  assign lk_hit  = |lk_match;
  assign sel_vec = (|wr_match) ? wr_match : victim_vec;

  always_comb begin
    lk_target = '0;
    sel_age   = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lk_match[i]) lk_target = lk_target | tgt_q[i];
      if (sel_vec[i])  sel_age   = sel_age | age_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        tag_q[i] <= '0;
        tgt_q[i] <= '0;
        age_q[i] <= AGE_W'(i);
      end
    end else if (wr_en) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (sel_vec[i]) begin
          valid_q[i] <= 1'b1;
          tag_q[i]   <= wr_tag;
          tgt_q[i]   <= wr_target;
          age_q[i]   <= '0;
        end else if (age_q[i] < sel_age) begin
          age_q[i] <= age_q[i] + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/bp_ret_stack.sv
module bp_ret_stack #(
  parameter int PC_W  = 32,
  parameter int DEPTH = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     push,
  input  logic [PC_W-1:0]          push_addr,
  input  logic                     pop,
  output logic [PC_W-1:0]          top_addr,
  output logic [$clog2(DEPTH):0]   count
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [PC_W-1:0]  slot_q [DEPTH];
  logic [PTR_W-1:0] ptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_pop;

  // circular buffer: a push past the depth simply overwrites the oldest slot
  assign top_addr = slot_q[ptr_q - 1'b1];
  assign count    = cnt_q;
  assign do_pop   = pop && (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
    end else if (push) begin
      slot_q[ptr_q] <= push_addr;
      ptr_q         <= ptr_q + 1'b1;
      if (cnt_q != FULL) cnt_q <= cnt_q + 1'b1;
    end else if (do_pop) begin
      ptr_q <= ptr_q - 1'b1;
      cnt_q <= cnt_q - 1'b1;
    end
  end

endmodule

// File: rtl/bp_frontend.sv
module bp_frontend import bp_pkg::*; #(
  parameter int PC_W        = 32,
  parameter int IDX_W       = 13,
  parameter int LANE_W      = 3,
  parameter int BTC_ENTRIES = 16,
  parameter int RAS_DEPTH   = 16,
  parameter int ALIGN       = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fetch_valid,
  input  logic [PC_W-1:0]  fetch_pc,
  input  logic [1:0]       fetch_kind,
  output logic             pred_taken,
  output logic             pred_hit,
  output logic [PC_W-1:0]  pred_target,
  output logic [IDX_W-1:0] pred_ghr,
  input  logic             upd_valid,
  input  logic [PC_W-1:0]  upd_pc,
  input  logic [1:0]       upd_kind,
  input  logic             upd_taken,
  input  logic [PC_W-1:0]  upd_target,
  input  logic [IDX_W-1:0] upd_ghr,
  input  logic             upd_mispredict
);
  localparam int TAG_W = PC_W - ALIGN;
  localparam int CNT_W = $clog2(RAS_DEPTH) + 1;
  localparam logic [PC_W-1:0] STEP = PC_W'(1 << ALIGN);

  // named internal events
  logic                   fetch_cond, fetch_call, fetch_ret;
  logic                   flush, dir_wr, btc_wr;
  logic [1:0]             dir_ctr;
  logic                   btc_hit;
  logic [PC_W-1:0]        btc_tgt;
  logic [BTC_ENTRIES-1:0] btc_victim;
  logic [PC_W-1:0]        ras_top;
  logic [CNT_W-1:0]       ras_count;
  logic                   ras_live;
  logic [PC_W-1:0]        fall_pc;
  logic [IDX_W-1:0]       ghr_q;
  logic [ALIGN-1:0]       unused_upd_lsbs;

  assign unused_upd_lsbs = upd_pc[ALIGN-1:0];

  assign fetch_cond = fetch_valid && (fetch_kind == BK_COND);
  assign fetch_call = fetch_valid && (fetch_kind == BK_CALL);
  assign fetch_ret  = fetch_valid && (fetch_kind == BK_RET);
  assign flush      = upd_valid && upd_mispredict;
  assign dir_wr     = upd_valid && (upd_kind == BK_COND);
  assign btc_wr     = upd_valid && upd_taken && ((upd_kind == BK_COND) || (upd_kind == BK_CALL));
  assign ras_live   = (ras_count != '0);
  assign fall_pc    = fetch_pc + STEP;
  assign pred_ghr   = ghr_q;

  bp_dir_table #(.IDX_W(IDX_W), .LANE_W(LANE_W)) u_dir (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_bits  (fetch_pc[ALIGN +: IDX_W]),
    .rd_hist  (ghr_q),
    .rd_ctr   (dir_ctr),
    .wr_en    (dir_wr),
    .wr_bits  (upd_pc[ALIGN +: IDX_W]),
    .wr_hist  (upd_ghr),
    .wr_taken (upd_taken)
  );

  bp_target_cache #(.PC_W(PC_W), .TAG_W(TAG_W), .ENTRIES(BTC_ENTRIES)) u_btc (
    .clk        (clk),
    .rst_n      (rst_n),
    .lk_tag     (fetch_pc[PC_W-1:ALIGN]),
    .lk_hit     (btc_hit),
    .lk_target  (btc_tgt),
    .wr_en      (btc_wr),
    .wr_tag     (upd_pc[PC_W-1:ALIGN]),
    .wr_target  (upd_target),
    .victim_vec (btc_victim)
  );

  bp_ret_stack #(.PC_W(PC_W), .DEPTH(RAS_DEPTH)) u_ras (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (fetch_call),
    .push_addr (fall_pc),
    .pop       (fetch_ret),
    .top_addr  (ras_top),
    .count     (ras_count)
  );

  // prediction path
  always_comb begin
    pred_taken  = 1'b0;
    pred_hit    = 1'b0;
    pred_target = fall_pc;
    case (fetch_kind)
      BK_COND: begin
        pred_hit   = btc_hit;
        pred_taken = btc_hit && ctr_says_taken(dir_ctr);
        if (pred_taken) pred_target = btc_tgt;
      end
      BK_CALL: begin
        pred_hit   = btc_hit;
        pred_taken = btc_hit;
        if (btc_hit) pred_target = btc_tgt;
      end
      BK_RET: begin
        pred_hit   = ras_live;
        pred_taken = ras_live;
        if (ras_live) pred_target = ras_top;
      end
      default: ;
    endcase
  end

  // global history: flush restore wins over speculative shift
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ghr_q <= '0;
    end else if (flush) begin
      ghr_q <= (upd_kind == BK_COND) ? {upd_ghr[IDX_W-2:0], upd_taken} : upd_ghr;
    end else if (fetch_cond) begin
      ghr_q <= {ghr_q[IDX_W-2:0], pred_taken};
    end
  end

endmodule

// File: rtl/bp_frontend_chk.sv
module bp_frontend_chk #(
  parameter int PC_W        = 32,
  parameter int IDX_W       = 13,
  parameter int BTC_ENTRIES = 16,
  parameter int RAS_DEPTH   = 16,
  parameter int ALIGN       = 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   fetch_valid,
  input logic [PC_W-1:0]        fetch_pc,
  input logic [1:0]             fetch_kind,
  input logic                   pred_taken,
  input logic                   pred_hit,
  input logic [PC_W-1:0]        pred_target,
  input logic [IDX_W-1:0]       pred_ghr,
  input logic                   upd_valid,
  input logic [1:0]             upd_kind,
  input logic                   upd_taken,
  input logic [IDX_W-1:0]       upd_ghr,
  input logic                   upd_mispredict,
  input logic [$clog2(RAS_DEPTH):0] ras_count,
  input logic                   btc_hit,
  input logic [BTC_ENTRIES-1:0] btc_victim
);
  localparam int CNT_W = $clog2(RAS_DEPTH) + 1;
  localparam logic [CNT_W-1:0] FULL = CNT_W'(RAS_DEPTH);
  localparam logic [PC_W-1:0] STEP = PC_W'(1 << ALIGN);

  // R4
  ghr_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid && fetch_kind == 2'b01 && !(upd_valid && upd_mispredict)
    |=> pred_ghr == {$past(pred_ghr[IDX_W-2:0]), $past(pred_taken)});

  // R5
  flush_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid && upd_mispredict && upd_kind == 2'b01
    |=> pred_ghr == {$past(upd_ghr[IDX_W-2:0]), $past(upd_taken)});

  // R5
  flush_plain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid && upd_mispredict && upd_kind != 2'b01 |=> pred_ghr == $past(upd_ghr));

  // R12
  ghr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(upd_valid && upd_mispredict) && !(fetch_valid && fetch_kind == 2'b01) |=> $stable(pred_ghr));

  // R12
  nonbranch_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_kind == 2'b00 |-> !pred_hit && !pred_taken && pred_target == fetch_pc + STEP);

  // R2
  cond_needs_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_kind == 2'b01 |-> (pred_hit == btc_hit) && (!pred_taken || btc_hit));

  // R9
  ret_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_kind == 2'b11 && ras_count != '0 |-> pred_hit && pred_taken);

  // R9
  ret_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid && fetch_kind == 2'b11 && ras_count != '0 |=> ras_count == $past(ras_count) - 1'b1);

  // R11
  ret_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_kind == 2'b11 && ras_count == '0 |-> !pred_hit && !pred_taken && pred_target == fetch_pc + STEP);

  // R10
  ras_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) ras_count <= FULL);

  // R10
  ras_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid && fetch_kind == 2'b10
    |=> ras_count == (($past(ras_count) == FULL) ? FULL : $past(ras_count) + 1'b1));

  // R7
  victim_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(btc_victim) == 1);

endmodule

bind bp_frontend bp_frontend_chk #(
  .PC_W(PC_W), .IDX_W(IDX_W), .BTC_ENTRIES(BTC_ENTRIES), .RAS_DEPTH(RAS_DEPTH), .ALIGN(ALIGN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
  .fetch_kind(fetch_kind), .pred_taken(pred_taken), .pred_hit(pred_hit),
  .pred_target(pred_target), .pred_ghr(pred_ghr), .upd_valid(upd_valid),
  .upd_kind(upd_kind), .upd_taken(upd_taken), .upd_ghr(upd_ghr),
  .upd_mispredict(upd_mispredict), .ras_count(ras_count), .btc_hit(btc_hit),
  .btc_victim(btc_victim)
);

// File: tb/bp_frontend_test.sv
module bp_frontend_test;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_valid = 1'b0;
  logic [31:0] fetch_pc = '0;
  logic [1:0]  fetch_kind = 2'b00;
  logic        pred_taken, pred_hit;
  logic [31:0] pred_target;
  logic [12:0] pred_ghr;
  logic        upd_valid = 1'b0;
  logic [31:0] upd_pc = '0;
  logic [1:0]  upd_kind = 2'b00;
  logic        upd_taken = 1'b0;
  logic [31:0] upd_target = '0;
  logic [12:0] upd_ghr = '0;
  logic        upd_mispredict = 1'b0;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  bp_frontend uut (.*);

  // independent reference model
  bit [1:0]    m_ctr [int];
  logic [31:0] m_tag [16];
  logic [31:0] m_tgt [16];
  bit          m_val [16];
  longint      m_use [16];
  longint      now = 0;
  logic [31:0] m_ras [$];
  logic [12:0] m_ghr = '0;
  string       ghr_lbl = "R1";

  function automatic int m_index(logic [31:0] pc, logic [12:0] h);
    return int'(({19'd0, h} ^ (pc >> 2)) & 32'h1fff);
  endfunction

  function automatic bit [1:0] m_get(int i);
    return m_ctr.exists(i) ? m_ctr[i] : 2'd1;
  endfunction

  function automatic int m_find(logic [31:0] pc);
    for (int i = 0; i < 16; i++) if (m_val[i] && (m_tag[i] >> 2) == (pc >> 2)) return i;
    return -1;
  endfunction

  function automatic int m_pick_victim();
    int v = -1;
    for (int i = 15; i >= 0; i--) if (!m_val[i]) return i;
    for (int i = 0; i < 16; i++) if (v < 0 || m_use[i] < m_use[v]) v = i;
    return v;
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(string lbl, bit fv, logic [31:0] fpc, logic [1:0] fk,
                      bit uv, logic [31:0] upc, logic [1:0] uk, bit ut,
                      logic [31:0] utg, logic [12:0] ugh, bit um);
    bit e_tk, e_hit;
    logic [31:0] e_tgt;
    int b, c;
    @(negedge clk);
    fetch_valid = fv; fetch_pc = fpc; fetch_kind = fk;
    upd_valid = uv; upd_pc = upc; upd_kind = uk; upd_taken = ut;
    upd_target = utg; upd_ghr = ugh; upd_mispredict = um;
    #1;
    e_tk = 0; e_hit = 0; e_tgt = fpc + 4;
    b = m_find(fpc);
    if (fk == 2'b01) begin
      e_hit = (b >= 0);
      e_tk = e_hit && (m_get(m_index(fpc, m_ghr)) >= 2);
      if (e_tk) e_tgt = m_tgt[b];
    end else if (fk == 2'b10) begin
      e_hit = (b >= 0); e_tk = e_hit;
      if (e_hit) e_tgt = m_tgt[b];
    end else if (fk == 2'b11) begin
      e_hit = (m_ras.size() > 0); e_tk = e_hit;
      if (e_hit) e_tgt = m_ras[m_ras.size()-1];
    end
    chk(lbl, "taken", {31'd0, pred_taken}, {31'd0, e_tk});
    chk(lbl, "hit", {31'd0, pred_hit}, {31'd0, e_hit});
    chk(lbl, "target", pred_target, e_tgt);
    chk(ghr_lbl, "ghr", {19'd0, pred_ghr}, {19'd0, m_ghr});
    // model state update at the coming edge
    if (fv && fk == 2'b10) begin
      if (m_ras.size() == 16) void'(m_ras.pop_front());
      m_ras.push_back(fpc + 4);
    end
    if (fv && fk == 2'b11 && m_ras.size() > 0) void'(m_ras.pop_back());
    if (uv && uk == 2'b01) begin
      c = int'(m_get(m_index(upc, ugh))) + (ut ? 1 : -1);
      if (c < 0) c = 0;
      if (c > 3) c = 3;
      m_ctr[m_index(upc, ugh)] = 2'(c);
    end
    if (uv && ut && (uk == 2'b01 || uk == 2'b10)) begin
      b = m_find(upc);
      if (b < 0) b = m_pick_victim();
      m_val[b] = 1; m_tag[b] = upc; m_tgt[b] = utg; m_use[b] = now++;
    end
    if (uv && um) begin
      m_ghr = (uk == 2'b01) ? {ugh[11:0], ut} : ugh;
      ghr_lbl = "R5";
    end else if (fv && fk == 2'b01) begin
      m_ghr = {m_ghr[11:0], e_tk};
      ghr_lbl = "R4";
    end else ghr_lbl = "R12";
  endtask

  task automatic fetch(string lbl, logic [31:0] pc, logic [1:0] k);
    step(lbl, 1, pc, k, 0, 32'h0, 2'b00, 0, 32'h0, 13'h0, 0);
  endtask

  task automatic resolve(string lbl, logic [31:0] pc, logic [1:0] k, bit t,
                         logic [31:0] tg, logic [12:0] gh, bit mis);
    step(lbl, 0, 32'h0, 2'b00, 1, pc, k, t, tg, gh, mis);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin
      m_val[i] = 0; m_tag[i] = '0; m_tgt[i] = '0; m_use[i] = 0;
    end
    void'($urandom(32'd20251));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1", "ghr", {19'd0, pred_ghr}, 32'd0);
    fetch("R1", 32'h0000_0100, 2'b01);
    fetch("R1", 32'h0000_0200, 2'b11);
    fetch("R1", 32'h0000_0300, 2'b10);

    // R3 saturation at history 0, with the target cached (R2)
    resolve("R3", 32'h0000_1000, 2'b01, 1, 32'h0000_5000, 13'h0, 0);
    resolve("R3", 32'h0000_1000, 2'b01, 1, 32'h0000_5000, 13'h0, 0);
    resolve("R3", 32'h0000_1000, 2'b01, 1, 32'h0000_5000, 13'h0, 0);
    resolve("R3", 32'h0000_1000, 2'b01, 1, 32'h0000_5000, 13'h0, 0);
    resolve("R5", 32'h0, 2'b00, 0, 32'h0, 13'h0, 1);
    fetch("R2", 32'h0000_1000, 2'b01);
    resolve("R5", 32'h0, 2'b00, 0, 32'h0, 13'h0, 1);
    resolve("R3", 32'h0000_1000, 2'b01, 0, 32'h0, 13'h0, 0);
    fetch("R3", 32'h0000_1000, 2'b01);
    resolve("R5", 32'h0, 2'b00, 0, 32'h0, 13'h0, 1);
    resolve("R3", 32'h0000_1000, 2'b01, 0, 32'h0, 13'h0, 0);
    resolve("R3", 32'h0000_1000, 2'b01, 0, 32'h0, 13'h0, 0);
    resolve("R3", 32'h0000_1000, 2'b01, 0, 32'h0, 13'h0, 0);
    fetch("R3", 32'h0000_1000, 2'b01);

    // R6 returns and not-taken resolutions never allocate
    resolve("R6", 32'h0000_2000, 2'b11, 1, 32'h0000_6000, 13'h0, 0);
    resolve("R6", 32'h0000_2004, 2'b01, 0, 32'h0000_6004, 13'h0, 0);
    fetch("R6", 32'h0000_2000, 2'b10);
    fetch("R6", 32'h0000_2004, 2'b10);
    resolve("R6", 32'h0000_1000, 2'b10, 1, 32'h0000_7700, 13'h0, 0);
    fetch("R6", 32'h0000_1000, 2'b10);

    // R7 fill, refresh the first, then evict the least recent
    for (int i = 0; i < 17; i++) begin
      resolve("R7", 32'h0000_8000 + 32'(i) * 32'h100, 2'b10, 1, 32'h0009_0000 + 32'(i) * 4, 13'h0, 0);
      if (i == 15) resolve("R7", 32'h0000_8000, 2'b10, 1, 32'h0009_1000, 13'h0, 0);
    end
    for (int i = 0; i < 17; i++) fetch("R7", 32'h0000_8000 + 32'(i) * 32'h100, 2'b00 + 2'b10);
    fetch("R7", 32'h0000_1000, 2'b10);

    // drain calls made so far, then R8/R10 overflow and R9/R11 unwinding
    for (int i = 0; i < 40; i++) fetch("R11", 32'h0000_3000, 2'b11);
    for (int i = 0; i < 18; i++) fetch("R8", 32'h0000_a000 + 32'(i) * 32'h10, 2'b10);
    for (int i = 0; i < 16; i++) fetch("R10", 32'h0000_b000, 2'b11);
    fetch("R11", 32'h0000_b000, 2'b11);
    resolve("R9", 32'h0000_c000, 2'b10, 1, 32'h0000_d000, 13'h0, 0);
    fetch("R8", 32'h0000_c000, 2'b10);
    fetch("R9", 32'h0000_c004, 2'b11);

    // R5 flush against a same-cycle conditional fetch; R12 non-branch
    fetch("R4", 32'h0000_1000, 2'b01);
    step("R5", 1, 32'h0000_1000, 2'b01, 1, 32'h0000_1000, 2'b01, 1, 32'h0000_5000, 13'h0abc, 1);
    step("R5", 1, 32'h0000_1000, 2'b01, 1, 32'h0000_2000, 2'b10, 0, 32'h0, 13'h1555, 1);
    fetch("R12", 32'h0000_1000, 2'b00);
    step("R12", 0, 32'h0000_1000, 2'b01, 0, 32'h0, 2'b00, 0, 32'h0, 13'h0, 0);
    fetch("R12", 32'h0000_4444, 2'b00);

    // constrained random mix
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] fpc, upc, utg;
      logic [12:0] gh;
      int g;
      fpc = 32'h0001_0000 + 32'($urandom_range(0, 23)) * 32'h1c;
      upc = 32'h0001_0000 + 32'($urandom_range(0, 23)) * 32'h1c;
      utg = {$urandom, 2'b00};
      g = $urandom_range(0, 3);
      gh = (g == 0) ? 13'h0 : (g == 1) ? 13'h0055 : (g == 2) ? 13'h1fff : 13'($urandom);
      step("R2", $urandom_range(0, 3) != 0, fpc, 2'($urandom),
           $urandom_range(0, 1) == 1, upc, 2'($urandom), $urandom_range(0, 2) != 0,
           utg, gh, $urandom_range(0, 7) == 0);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule